// File: doc/BRIEF.md
# Parallel Bus Register and Result Port

This block is the peripheral end of a 16-bit parallel host bus that has one chip select and one direction strobe. It serves two kinds of traffic. Host writes go into a small bank of 16-bit configuration registers. The first write of a pair is an address and the second is the data for that address. Host reads return the newest conversion result as two words, or, when the host has asked for it, one register. A converter stage outside this block supplies each result on a one-cycle valid input. The block then raises an active-low data-ready pulse so the host knows to collect the result.

The bus is tristate, but here it is modelled as three separate signals: an input word, an output word and an output enable. All strobes are sampled on the block clock. The host holds the block idle until it sends a single power-up command, which sets the run bit. Register readback takes two steps. The host first sets a per-address select bit in the control register. The next read then returns that register in place of conversion data, and the select bits clear themselves afterwards.

Top module: `pbus_port`

## Requirements
- R1: After reset, bus_oe is 0, drdy_n is 1, run is 0, the address/data toggle expects an address, and the held result is zero, so the first read returns 16'h0000.
- R2: bus_oe is 1 only while cs_n is 0 and dir_wr is 0, and bus_out is 16'h0000 whenever bus_oe is 0.
- R3: A write is one access with cs_n low and dir_wr high, and its value is taken in the first cycle of that access. Writes alternate. The first write carries a register address in bits [3:0], and the second write stores its value in that register. The control register is at address 1 and the configuration registers are at addresses 2 and 3.
- R4: Any read that takes place after an address write and before its data write cancels the pending address, so the next write is again taken as an address.
- R5: An address-phase write with bit 15 set is a power-up command. It sets the run bit (control bit 0, also driven on the run output) and leaves no data phase pending.
- R6: A res_valid cycle is accepted only while run is 1. When it is accepted, the block stores the result and drives drdy_n low for exactly the next cycle. A res_valid cycle while run is 0 changes nothing.
- R7: Conversion reads alternate between two words. The first word is result bits [23:16..8], that is res_data[23:8]. The second word is {res_data[7:0], res_stat[7:0]}. After the second word, the next read returns the first word again.
- R8: An accepted result always restarts the sequence, so the next conversion read returns the first word.
- R9: Control bit 4+a selects address a for readback, for a from 0 to 3. While any select bit is set, the next read returns the register with the lowest selected address. At the end of that read all select bits clear, and the conversion word sequence stays where it was.
- R10: Writes to unimplemented addresses (0 and 4 to 15) change no register. A readback of address 0 returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| dir_wr | input | 1 | Access direction: 1 for a write, 0 for a read |
| bus_in | input | 16 | Word driven by the host during writes |
| bus_out | output | 16 | Word driven toward the host during reads |
| bus_oe | output | 1 | Output enable for the bus drivers |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | 24 | Conversion result |
| res_stat | input | 8 | Status byte that accompanies the result |
| drdy_n | output | 1 | Active-low data-ready pulse |
| run | output | 1 | Converter enable, which is control bit 0 |

## Verification
The bench places a read between an address write and its data write. If a design kept the pending address, the bench would see it store the following address word as data, and that value would show up wrongly in a later readback. The bench sets two select bits together: a design with the wrong priority returns the wrong register, and a design that did not clear the select bits would keep returning register data in place of the conversion word. The bench also sends results before the power-up command, sends a new result between the two halves of a conversion read, and writes to dead addresses. A design that latches results while idle, or that fails to restart the word order, or that decodes dead addresses, produces a word the bench does not expect.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int DW        = 16;
    localparam int ADDR_W    = 4;
    localparam int CTRL_ADDR = 1;
    localparam int RUN_BIT   = 0;
    localparam int SEL_LSB   = 4;
    localparam int PWR_BIT   = 15;
    typedef logic [DW-1:0]     word_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/pbus_strobe.sv
module pbus_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic dir_wr,
    output logic rd_act,
    output logic rd_start,
    output logic rd_end,
    output logic wr_start
);
    typedef struct packed {
        logic rd;
        logic wr;
    } strb_t;

    strb_t st_d, st_q;
    logic  wr_act;

    always_comb begin
        rd_act   = !cs_n && !dir_wr;
        wr_act   = !cs_n && dir_wr;
        st_d.rd  = rd_act;
        st_d.wr  = wr_act;
        rd_start = rd_act && !st_q.rd;
        rd_end   = !rd_act && st_q.rd;
        wr_start = wr_act && !st_q.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
    import pbus_pkg::*;
#(
    parameter int NUM_CFG = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_start,
    input  logic  rd_start,
    input  logic  rd_end,
    input  word_t wr_val,
    output logic  run,
    output logic [NUM_CFG+1:0] sel,
    output word_t reg_val [NUM_CFG+2]
);
    localparam int SEL_N = NUM_CFG + 2;

    typedef struct packed {
        logic                      pend;
        addr_t                     addr;
        word_t                     ctrl;
        logic [NUM_CFG-1:0][DW-1:0] cfg;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic sel_any;

    always_comb begin
        rf_d    = rf_q;
        sel_any = |rf_q.ctrl[SEL_LSB +: SEL_N];
        if (rd_start) rf_d.pend = 1'b0;
        if (rd_end && sel_any) rf_d.ctrl[SEL_LSB +: SEL_N] = '0;
        if (wr_start) begin
            if (!rf_q.pend) begin
                if (wr_val[PWR_BIT]) begin
                    rf_d.ctrl[RUN_BIT] = 1'b1;
                end else begin
                    rf_d.pend = 1'b1;
                    rf_d.addr = wr_val[ADDR_W-1:0];
                end
            end else begin
                rf_d.pend = 1'b0;
                if (rf_q.addr == addr_t'(CTRL_ADDR)) rf_d.ctrl = wr_val;
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (rf_q.addr == addr_t'(CTRL_ADDR + 1 + i)) rf_d.cfg[i] = wr_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign run        = rf_q.ctrl[RUN_BIT];
    assign sel        = rf_q.ctrl[SEL_LSB +: SEL_N];
    assign reg_val[0] = '0;
    assign reg_val[1] = rf_q.ctrl;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        assign reg_val[g+2] = rf_q.cfg[g];
    end

    // R4
    rd_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rf_q.pend);
    // R5
    pwr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !rf_q.pend && wr_val[PWR_BIT]) |=> (run && !rf_q.pend));
    // R9
    sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && sel_any && !wr_start) |=> (sel == '0));
endmodule

// File: rtl/pbus_result.sv
module pbus_result
    import pbus_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic             run,
    input  logic [RES_W-1:0] res_data,
    input  logic [2*DW-RES_W-1:0] res_stat,
    input  logic             rd_end,
    input  logic             sel_any,
    output word_t            conv_word,
    output logic             drdy_n
);
    localparam int LO_W   = RES_W - DW;
    localparam int STAT_W = 2*DW - RES_W;

    typedef struct packed {
        logic [RES_W-1:0]  res;
        logic [STAT_W-1:0] stat;
        logic              lo;
        logic              rdy_n;
    } cv_t;

    cv_t  cv_d, cv_q;
    logic take;

    always_comb begin
        cv_d = cv_q;
        take = res_valid && run;
        cv_d.rdy_n = !take;
        if (rd_end && !sel_any) cv_d.lo = !cv_q.lo;
        if (take) begin
            cv_d.res  = res_data;
            cv_d.stat = res_stat;
            cv_d.lo   = 1'b0;
        end
        conv_word = cv_q.lo ? {cv_q.res[LO_W-1:0], cv_q.stat} : cv_q.res[RES_W-1:LO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cv_q <= '{res: '0, stat: '0, lo: 1'b0, rdy_n: 1'b1};
        else        cv_q <= cv_d;
    end

    assign drdy_n = cv_q.rdy_n;

    // R6
    drdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(res_valid && run));
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |-> !cv_q.lo);
endmodule

// File: rtl/pbus_port.sv
module pbus_port
    import pbus_pkg::*;
#(
    parameter int NUM_CFG = 2,
    parameter int RES_W   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    dir_wr,
    input  logic [DW-1:0]           bus_in,
    output logic [DW-1:0]           bus_out,
    output logic                    bus_oe,
    input  logic                    res_valid,
    input  logic [RES_W-1:0]        res_data,
    input  logic [2*DW-RES_W-1:0]   res_stat,
    output logic                    drdy_n,
    output logic                    run
);
    localparam int SEL_N = NUM_CFG + 2;

    logic             rd_act, rd_start, rd_end, wr_start;
    logic [SEL_N-1:0] sel;
    logic             sel_any;
    word_t            reg_val [SEL_N];
    word_t            conv_word, rb_word;

    pbus_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir_wr(dir_wr),
        .rd_act(rd_act), .rd_start(rd_start), .rd_end(rd_end), .wr_start(wr_start)
    );

    pbus_regfile #(.NUM_CFG(NUM_CFG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
        .rd_end(rd_end), .wr_val(bus_in), .run(run), .sel(sel), .reg_val(reg_val)
    );

    pbus_result #(.RES_W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .run(run),
        .res_data(res_data), .res_stat(res_stat), .rd_end(rd_end),
        .sel_any(sel_any), .conv_word(conv_word), .drdy_n(drdy_n)
    );

    always_comb begin
        sel_any = |sel;
        rb_word = '0;
        for (int a = SEL_N - 1; a >= 0; a--) begin
            if (sel[a]) rb_word = reg_val[a];
        end
        bus_oe  = rd_act;
        bus_out = rd_act ? (sel_any ? rb_word : conv_word) : '0;
    end

    // R2
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!cs_n && !dir_wr));
endmodule

// File: tb/pbus_port_tb_top.sv
`timescale 1ns/1ps
module pbus_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        dir_wr = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic [7:0]  res_stat = '0;
    logic        drdy_n;
    logic        run;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // reference model kept from the requirements
    logic [15:0] m_ctrl = '0;
    logic [15:0] m_cfg2 = '0;
    logic [15:0] m_cfg3 = '0;
    logic [23:0] m_res = '0;
    logic [7:0]  m_stat = '0;
    bit          m_lo = 0;
    bit          m_pend = 0;
    logic [3:0]  m_addr = '0;

    always #2.5 clk = ~clk;

    pbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir_wr(dir_wr), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .res_valid(res_valid), .res_data(res_data),
        .res_stat(res_stat), .drdy_n(drdy_n), .run(run)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] reg_of(input int a);
        case (a)
            1: return m_ctrl;
            2: return m_cfg2;
            3: return m_cfg3;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic host_write(input logic [15:0] v);
        @(negedge clk);
        cs_n = 1'b0; dir_wr = 1'b1; bus_in = v;
        #1 check("R2 oe during write", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        cs_n = 1'b1;
        if (!m_pend) begin
            if (v[15]) m_ctrl[0] = 1'b1;
            else begin m_pend = 1; m_addr = v[3:0]; end
        end else begin
            m_pend = 0;
            case (m_addr)
                4'd1: m_ctrl = v;
                4'd2: m_cfg2 = v;
                4'd3: m_cfg3 = v;
                default: ;
            endcase
        end
    endtask

    task automatic host_read(input string req);
        logic [15:0] e;
        @(negedge clk);
        m_pend = 0;
        if (|m_ctrl[7:4]) begin
            e = 16'h0000;
            for (int a = 3; a >= 0; a--) if (m_ctrl[4+a]) e = reg_of(a);
            m_ctrl[7:4] = 4'h0;
        end else begin
            e = m_lo ? {m_res[7:0], m_stat} : m_res[23:8];
            m_lo = !m_lo;
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
        cs_n = 1'b0; dir_wr = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; dir_wr = 1'b1;
        #1;
        check("R2 oe after read", {31'd0, bus_oe}, 32'd0);
        check("R2 bus idle", {16'd0, bus_out}, 32'd0);
    endtask

    task automatic push_result(input logic [23:0] d, input logic [7:0] s);
        bit acc;
        @(negedge clk);
        acc = m_ctrl[0];
        res_valid = 1'b1; res_data = d; res_stat = s;
        @(negedge clk);
        res_valid = 1'b0;
        if (acc) begin m_res = d; m_stat = s; m_lo = 0; end
        check("R6 drdy low", {31'd0, drdy_n}, {31'd0, !acc});
        @(negedge clk);
        check("R6 drdy back high", {31'd0, drdy_n}, 32'd1);
    endtask

    // monitor: pops one expected word per read access
    always @(posedge clk) begin
        #2;
        if (rst_n && bus_oe) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected read actual=%h expected=none", bus_out);
            end else begin
                check(tag_q.pop_front(), {16'd0, bus_out}, {16'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", {31'd0, bus_oe}, 32'd0);
        check("R1 drdy", {31'd0, drdy_n}, 32'd1);
        check("R1 run", {31'd0, run}, 32'd0);
        host_read("R1 zero result");
        // R2: chip selected but writing direction, then deselected reading direction
        @(negedge clk); cs_n = 1'b1; dir_wr = 1'b0;
        #1 check("R2 cs high", {31'd0, bus_oe}, 32'd0);
        @(negedge clk); dir_wr = 1'b1;
        // R6: ignored while not running
        push_result(24'hA1B2C3, 8'h5A);
        host_read("R6 idle result ignored");
        // R5: power-up command
        host_write(16'h8000);
        check("R5 run", {31'd0, run}, 32'd1);
        host_write(16'h0002);
        host_write(16'h1234);
        // R7 word order
        push_result(24'hC0FFEE, 8'h3C);
        host_read("R7 first word");
        host_read("R7 second word");
        host_read("R7 wraps to first");
        // R8 restart between halves
        push_result(24'h123456, 8'h81);
        host_read("R8 first word");
        push_result(24'h89ABCD, 8'h7E);
        host_read("R8 restarted word");
        // R3 address then data
        host_write(16'h0002); host_write(16'hBEEF);
        host_write(16'h0003); host_write(16'h0F0F);
        // R4 read cancels pending address
        host_write(16'h0002);
        host_read("R4 intervening read");
        host_write(16'h0003);
        host_write(16'h5555);
        // R10 dead addresses
        host_write(16'h0000); host_write(16'hFFFF);
        host_write(16'h0009); host_write(16'h7777);
        // R9 readback with priority
        host_write(16'h0001); host_write(16'h00C1);
        host_read("R9 lowest selected (R3 cfg2)");
        host_read("R9 select cleared, conversion");
        host_write(16'h0001); host_write(16'h0081);
        host_read("R9 readback cfg3 (R4 R3)");
        host_write(16'h0001); host_write(16'h0011);
        host_read("R10 readback address zero");
        host_write(16'h0001); host_write(16'h0021);
        host_read("R9 readback control");
        host_read("R9 back to conversion");
        check("R5 run kept", {31'd0, run}, 32'd1);
        repeat (4) @(negedge clk);
        check("R7 all reads served", exp_q.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule